// File: doc/BRIEF.md
# Status-Store Parameter Validator

This block screens the parameter of the three inter-processor orders that target memory: storing the register status to an address, storing the extended register status, and moving the target's low-memory base (prefix). From one 64-bit parameter, a snapshot of the target's stopped flag and two feature-enable bits, it either issues a request to a store engine (or a prefix write strobe) or ends the order with an error status.

One validation runs at a time. A one-cycle `start_i` captures the order type, the parameter, the stopped flag and the feature bits. The checks then run in a fixed priority order. The set-prefix order asks an external range checker whether the new base is valid. It waits in a dedicated state until that checker grants. A store order waits for the store engine's completion. In every case the order ends with a one-cycle `done_o` that carries a registered status.

Top module: `stsv_param_check`

## Requirements
- R1: The order type is 0 for store status at address, 1 for extended status store, 2 for set prefix, and 3 for unsupported. The status code is 0 for accepted, 1 for invalid order, 2 for incorrect state, and 3 for invalid parameter. An unsupported order ends with status 1 and issues no request.
- R2: For an extended status store, the length code is parameter bits [3:0]. The address is the full 64-bit parameter with bits [3:0] cleared. The length presented with `go_o` is 2 to the power of the code, and code 0 means 1024 bytes.
- R3: An extended status store with both feature bits clear ends with status 1. This applies whatever the stopped flag, alignment or code.
- R4: An extended status store with a feature enabled but a running target ends with status 2, even if the parameter would be invalid.
- R5: For a stopped target, an extended status address that is not a multiple of the length ends with status 3.
- R6: Without the guarded-storage feature, only code 0 is legal. With it, codes 0, 10, 11 and 12 are legal. Any other code ends with status 3.
- R7: Store status at address uses the parameter masked with 0x7FFFFE00. It requires a stopped target and otherwise ends with status 2.
- R8: Set prefix presents the parameter masked with 0x7FFFE000 on `addr_o` and holds `rng_req_o` until `rng_gnt_i`. A grant with `rng_ok_i` low ends with status 3, ahead of the stopped check. A valid range with a running target ends with status 2. Otherwise `prefix_we_o` pulses in the same cycle as `done_o`, with status 0.
- R9: After `go_o`, the order ends when `store_done_i` arrives. The status is 3 if `store_err_i` is high and 0 otherwise.
- R10: While `busy_o` is high, `start_i` is ignored. Each accepted start yields exactly one `done_o` pulse.
- R11: After reset, `busy_o`, `done_o`, `go_o`, `rng_req_o` and `prefix_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a validation (ignored while busy) |
| kind_i | input | 2 | Order type |
| param_i | input | 64 | Order parameter |
| stopped_i | input | 1 | Target is stopped (sampled at start) |
| feat_vec_i | input | 1 | Vector feature enabled (sampled at start) |
| feat_gs_i | input | 1 | Guarded-storage feature enabled (sampled at start) |
| rng_req_o | output | 1 | Range check request, held until grant |
| rng_gnt_i | input | 1 | Range check grant |
| rng_ok_i | input | 1 | Range is valid, qualified by grant |
| go_o | output | 1 | One-cycle store request |
| addr_o | output | 64 | Masked address for store, range check and prefix |
| len_o | output | 16 | Store length in bytes for extended status stores |
| store_done_i | input | 1 | Store engine finished |
| store_err_i | input | 1 | Store failed, qualified by done |
| prefix_we_o | output | 1 | New prefix write strobe |
| busy_o | output | 1 | A validation is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Result status, valid with done |

## Verification
Two events can fall in the same cycle: a completion from the store engine and a fresh `start_i` request. While the store engine asserts `store_done_i`, the bench also raises `start_i` with an unsupported order type. If that start were wrongly accepted, it would create a second completion with status 1. The scoreboard therefore expects only the original store result, and it reports any `done_o` that arrives with an empty expectation queue.

// File: rtl/stsv_param_check.sv
module stsv_param_check #(
  parameter int PW = 64,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    kind_i,
  input  logic [PW-1:0] param_i,
  input  logic          stopped_i,
  input  logic          feat_vec_i,
  input  logic          feat_gs_i,
  output logic          rng_req_o,
  input  logic          rng_gnt_i,
  input  logic          rng_ok_i,
  output logic          go_o,
  output logic [PW-1:0] addr_o,
  output logic [LW-1:0] len_o,
  input  logic          store_done_i,
  input  logic          store_err_i,
  output logic          prefix_we_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    status_o
);
  localparam logic [1:0] K_SSA = 2'd0, K_EXT = 2'd1, K_PFX = 2'd2;
  localparam logic [1:0] S_OK = 2'd0, S_BADORD = 2'd1, S_STATE = 2'd2, S_PARM = 2'd3;
  localparam logic [PW-1:0] SSA_MASK = PW'(32'h7FFF_FE00);
  localparam logic [PW-1:0] PFX_MASK = PW'(32'h7FFF_E000);
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] DEF_SH = CODE_W'(10);

  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_RANGE, ST_STORE} st_t;
  st_t st;

  logic [1:0]    kind_q;
  logic [PW-1:0] prm_q;
  logic          stop_q, vec_q, gs_q;
  logic          go_q, done_q, pw_q;
  logic [1:0]    sts_q;
  logic [PW-1:0] addr_q;
  logic [LW-1:0] len_q;

  logic [CODE_W-1:0] code, shamt;
  logic [PW-1:0]     ext_addr, len_mask, addr_sel;
  logic              misal, code_ok;

  assign code     = prm_q[CODE_W-1:0];
  assign shamt    = (code == '0) ? DEF_SH : code;
  assign ext_addr = {prm_q[PW-1:CODE_W], {CODE_W{1'b0}}};
  assign len_mask = (PW'(1) << shamt) - PW'(1);
  assign misal    = |(ext_addr & len_mask);
  assign code_ok  = (code == '0) ||
                    (gs_q && (code == 4'd10 || code == 4'd11 || code == 4'd12));

  always_comb begin
    case (kind_q)
      K_SSA:   addr_sel = prm_q & SSA_MASK;
      K_EXT:   addr_sel = ext_addr;
      default: addr_sel = prm_q & PFX_MASK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind_q <= '0;
      prm_q  <= '0;
      stop_q <= 1'b0;
      vec_q  <= 1'b0;
      gs_q   <= 1'b0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
      pw_q   <= 1'b0;
      sts_q  <= S_OK;
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      pw_q   <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          kind_q <= kind_i;
          prm_q  <= param_i;
          stop_q <= stopped_i;
          vec_q  <= feat_vec_i;
          gs_q   <= feat_gs_i;
          st     <= ST_CHECK;
        end
        ST_CHECK: begin
          addr_q <= addr_sel;
          len_q  <= (kind_q == K_EXT) ? (LW'(1) << shamt) : '0;
          case (kind_q)
            K_SSA: begin
              if (!stop_q) begin
                sts_q <= S_STATE; done_q <= 1'b1; st <= ST_IDLE;
              end else begin
                go_q <= 1'b1; st <= ST_STORE;
              end
            end
            K_EXT: begin
              if (!vec_q && !gs_q) begin
                sts_q <= S_BADORD; done_q <= 1'b1; st <= ST_IDLE;
              end else if (!stop_q) begin
                sts_q <= S_STATE; done_q <= 1'b1; st <= ST_IDLE;
              end else if (misal || !code_ok) begin
                sts_q <= S_PARM; done_q <= 1'b1; st <= ST_IDLE;
              end else begin
                go_q <= 1'b1; st <= ST_STORE;
              end
            end
            K_PFX: st <= ST_RANGE;
            default: begin
              sts_q <= S_BADORD; done_q <= 1'b1; st <= ST_IDLE;
            end
          endcase
        end
        ST_RANGE: if (rng_gnt_i) begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
          if (!rng_ok_i)     sts_q <= S_PARM;
          else if (!stop_q)  sts_q <= S_STATE;
          else begin
            sts_q <= S_OK;
            pw_q  <= 1'b1;
          end
        end
        ST_STORE: if (store_done_i) begin
          sts_q  <= store_err_i ? S_PARM : S_OK;
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rng_req_o   = (st == ST_RANGE);
  assign go_o        = go_q;
  assign addr_o      = addr_q;
  assign len_o       = len_q;
  assign prefix_we_o = pw_q;
  assign busy_o      = (st != ST_IDLE);
  assign done_o      = done_q;
  assign status_o    = sts_q;

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_o, done_o}));

  p_done_follows_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  p_go_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && len_o != '0) |-> ((addr_o & PW'(len_o - LW'(1))) == '0));

  p_go_len_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && kind_q == K_EXT) |->
      (len_o == LW'(1024) || len_o == LW'(2048) || len_o == LW'(4096)));

  p_ssa_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && kind_q == K_SSA) |-> ((addr_o & ~SSA_MASK) == '0));

  p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rng_req_o && !rng_gnt_i) |=> rng_req_o);

  p_prefix_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prefix_we_o |-> (done_o && status_o == S_OK));
endmodule

// File: tb/stsv_param_check_tb.sv
module stsv_param_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [63:0] param_i = '0;
  logic        stopped_i = 1'b0, feat_vec_i = 1'b0, feat_gs_i = 1'b0;
  logic        rng_req_o, rng_gnt_i = 1'b0, rng_ok_i = 1'b0;
  logic        go_o;
  logic [63:0] addr_o;
  logic [15:0] len_o;
  logic        store_done_i = 1'b0, store_err_i = 1'b0;
  logic        prefix_we_o, busy_o, done_o;
  logic [1:0]  status_o;

  int checks = 0, errors = 0;
  logic eng_err = 1'b0, rng_good = 1'b0, collide = 1'b0;

  logic [1:0]  q_st[$];
  logic        q_go[$], q_chklen[$], q_pw[$];
  logic [63:0] q_addr[$];
  logic [15:0] q_len[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  stsv_param_check u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i), .param_i(param_i),
    .stopped_i(stopped_i), .feat_vec_i(feat_vec_i), .feat_gs_i(feat_gs_i),
    .rng_req_o(rng_req_o), .rng_gnt_i(rng_gnt_i), .rng_ok_i(rng_ok_i),
    .go_o(go_o), .addr_o(addr_o), .len_o(len_o),
    .store_done_i(store_done_i), .store_err_i(store_err_i),
    .prefix_we_o(prefix_we_o), .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // store engine model
  initial forever begin
    @(negedge clk);
    if (go_o) begin
      repeat (2) @(negedge clk);
      store_done_i = 1'b1;
      store_err_i  = eng_err;
      if (collide) begin
        start_i = 1'b1;
        kind_i  = 2'd3;
      end
      @(negedge clk);
      store_done_i = 1'b0;
      store_err_i  = 1'b0;
      start_i      = 1'b0;
    end
  end

  // range checker model
  initial forever begin
    @(negedge clk);
    if (rng_req_o) begin
      repeat (2) @(negedge clk);
      rng_gnt_i = 1'b1;
      rng_ok_i  = rng_good;
      @(negedge clk);
      rng_gnt_i = 1'b0;
      rng_ok_i  = 1'b0;
    end
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (go_o) begin
        if (q_go.size() == 0 || !q_go[0]) chk("R1 unexpected go", 1, 0);
        else begin
          chk({q_tag[0], " go address"}, addr_o, q_addr[0]);
          if (q_chklen[0]) chk({q_tag[0], " go length R2"}, 64'(len_o), 64'(q_len[0]));
        end
      end
      if (rng_req_o && q_addr.size() != 0)
        chk({q_tag[0], " range address R8"}, addr_o, q_addr[0]);
      if (done_o) begin
        if (q_st.size() == 0) chk("R10 done with nothing pending", 1, 0);
        else begin
          chk({q_tag[0], " status"}, 64'(status_o), 64'(q_st[0]));
          chk({q_tag[0], " prefix strobe R8"}, 64'(prefix_we_o), 64'(q_pw[0]));
          if (q_pw[0]) chk({q_tag[0], " prefix address R8"}, addr_o, q_addr[0]);
          void'(q_st.pop_front()); void'(q_go.pop_front()); void'(q_addr.pop_front());
          void'(q_len.pop_front()); void'(q_chklen.pop_front()); void'(q_pw.pop_front());
          void'(q_tag.pop_front());
        end
      end else if (prefix_we_o) chk("R8 prefix strobe without done", 1, 0);
    end
  end

  task automatic run(input string tag, input logic [1:0] kind, input logic [63:0] prm,
                     input logic stp, input logic vec, input logic gs,
                     input logic rok, input logic eerr, input logic coll,
                     input logic [1:0] est, input logic ego, input logic [63:0] eaddr,
                     input logic [15:0] elen, input logic echklen, input logic epw);
    q_st.push_back(est); q_go.push_back(ego); q_addr.push_back(eaddr);
    q_len.push_back(elen); q_chklen.push_back(echklen); q_pw.push_back(epw);
    q_tag.push_back(tag);
    eng_err = eerr; rng_good = rok; collide = coll;
    kind_i = kind; param_i = prm; stopped_i = stp; feat_vec_i = vec; feat_gs_i = gs;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk({tag, " queue drained R10"}, 64'(q_st.size()), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", 64'(busy_o), 0);
    chk("R11 done in reset", 64'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 go after reset", 64'(go_o), 0);
    chk("R11 req after reset", 64'(rng_req_o), 0);
    chk("R11 prefix after reset", 64'(prefix_we_o), 0);

    run("R1 unsupported", 2'd3, 64'h5, 1, 1, 1, 1, 0, 0, 2'd1, 0, 0, 0, 0, 0);
    run("R7 ssa ok", 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 1, 0, 0, 2'd0, 1, 64'h7FFF_FE00, 0, 0, 0);
    run("R7 ssa running", 2'd0, 64'h1000, 0, 0, 0, 1, 0, 0, 2'd2, 0, 0, 0, 0, 0);
    run("R9 ssa store fail", 2'd0, 64'h0000_0000_1234_5678, 1, 0, 0, 1, 1, 0, 2'd3, 1, 64'h1234_5600, 0, 0, 0);
    run("R3 no features", 2'd1, 64'h123, 0, 0, 0, 1, 0, 0, 2'd1, 0, 0, 0, 0, 0);
    run("R4 running", 2'd1, 64'h123, 0, 1, 0, 1, 0, 0, 2'd2, 0, 0, 0, 0, 0);
    run("R2 code0 1024", 2'd1, 64'h1000, 1, 1, 0, 1, 0, 0, 2'd0, 1, 64'h1000, 16'd1024, 1, 0);
    run("R5 misaligned", 2'd1, 64'h1200, 1, 1, 0, 1, 0, 0, 2'd3, 0, 0, 0, 0, 0);
    run("R6 code11 no gs", 2'd1, 64'h400B, 1, 1, 0, 1, 0, 0, 2'd3, 0, 0, 0, 0, 0);
    run("R6 code11 gs", 2'd1, 64'h400B, 1, 0, 1, 1, 0, 0, 2'd0, 1, 64'h4000, 16'd2048, 1, 0);
    run("R2 code12 high addr", 2'd1, 64'h0000_0001_0000_000C, 1, 0, 1, 1, 0, 0, 2'd0, 1, 64'h0000_0001_0000_0000, 16'd4096, 1, 0);
    run("R6 code9 gs", 2'd1, 64'h8009, 1, 0, 1, 1, 0, 0, 2'd3, 0, 0, 0, 0, 0);
    run("R6 code13 gs", 2'd1, 64'h000D, 1, 1, 1, 1, 0, 0, 2'd3, 0, 0, 0, 0, 0);
    run("R9 ext store fail", 2'd1, 64'h480A, 1, 1, 1, 1, 1, 0, 2'd3, 1, 64'h4800, 16'd1024, 1, 0);
    run("R8 bad range first", 2'd2, 64'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 2'd3, 0, 64'h7FFF_E000, 0, 0, 0);
    run("R8 running", 2'd2, 64'h0000_0000_0002_3FFF, 0, 0, 0, 1, 0, 0, 2'd2, 0, 64'h2_2000, 0, 0, 0);
    run("R8 prefix ok", 2'd2, 64'hABCD_0000_8001_6000, 1, 0, 0, 1, 0, 0, 2'd0, 0, 64'h0001_6000, 0, 0, 1);
    run("R10 start collides with store done", 2'd0, 64'h200, 1, 0, 0, 1, 0, 1, 2'd0, 1, 64'h200, 0, 0, 0);
    chk("R10 idle after collision", 64'(busy_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule